// File: doc/BRIEF.md
# Stack and Branch Machine-Cycle Sequencer

This block runs the execution phase of the control-transfer and stack instructions of a small 8-bit processor core. It begins after the opcode has been fetched and decoded into an operation class. From that point it walks through machine cycles M1 to M5, one clock per cycle. In each cycle after M1 it issues at most one memory read or write, with the address and the write data. It also owns the program counter, the stack pointer and a two-byte scratch pair, W (high) and Z (low). When the cycle that ends the instruction is reached, it pulses `done` and returns to M1, ready for the next instruction.

The surrounding core keeps the accumulator, the flag byte and the register pairs BC, DE and HL, and feeds them in as inputs. Whatever the sequencer loads into them comes back on a single write-back channel. Memory answers reads in the same cycle through `mem_rdata`.

When an instruction starts, `pc` points at the byte just after the opcode. The cycle in which `start` is accepted is M1. Conditional branches, calls and returns test their condition in M1. A failing test ends the instruction in that same cycle. A passing test makes the instruction run exactly like its unconditional form.

Top module: `stk_branch_seq`

## Requirements
- R1: After reset, `pc` and `sp` are 0, `ready` is high, `mcycle` is 0 (M1), and no memory access is requested.
- R2: The condition field selects one of eight tests on the flag byte, in which sign is bit 7, zero is bit 6, parity is bit 2 and carry is bit 0. Codes 0 to 7 test, in order: zero clear, zero set, carry clear, carry set, parity clear, parity set, sign clear, sign set.
- R3: A conditional jump (op 1) or conditional call (op 3) whose test fails adds 2 to `pc`, leaves `sp` unchanged, makes no access, and asserts `done` in M1 (one cycle).
- R4: A jump (op 0, or op 1 with a passing test) reads the low target byte at `pc` and then the high byte at `pc`+1, loads `pc` with the target, and takes 3 cycles.
- R5: A call (op 2, or op 3 with a passing test) reads the target the same way and stores the return address `pc`+2: high byte at `sp`-1, low byte at `sp`-2. It then leaves `sp` lowered by 2 and `pc` at the target, and takes 5 cycles.
- R6: A return (op 4, or op 5 with a passing test) reads the low byte at `sp` and the high byte at `sp`+1, loads `pc` from them, raises `sp` by 2, and takes 3 cycles. Op 5 with a failing test takes 1 cycle and changes nothing.
- R7: A restart (op 6) with vector n (0 to 7) stores the current `pc` as a return address, laid out on the stack as in R5. It then sets `pc` to n×8 and takes 3 cycles.
- R8: A pair push (op 7, pair select 0 = BC, 1 = DE, 2 = HL) writes the high byte at `sp`-1 and the low byte at `sp`-2. The status push (op 8) writes the accumulator at `sp`-1 and the flag byte at `sp`-2, with bit 1 forced to 1 and bits 3 and 5 forced to 0. Both take 3 cycles, leave `sp` lowered by 2, and write the second byte one address below the first.
- R9: A pair pop (op 9) reads the low byte at `sp` and the high byte at `sp`+1, writes the pair back (destination 0 = BC, 1 = DE, 2 = HL), and raises `sp` by 2. The status pop (op 10) writes the byte at `sp` back to the flags (destination 3), and then the byte at `sp`+1 to the accumulator (destination 4). Both take 3 cycles.
- R10: The exchange (op 11) swaps HL with the two bytes at the top of the stack: L with `sp` and H with `sp`+1. HL is written back through destination 2, `sp` is unchanged at the end, and it takes 5 cycles.
- R11: The HL jump (op 12) copies HL into `pc`, makes no access, and completes in 1 cycle.
- R12: Ops 13 to 15 complete in 1 cycle, make no access, and leave `pc` and `sp` unchanged.
- R13: At most one memory access is requested in any cycle, and none in M1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an instruction; taken only while `ready` |
| op | input | 4 | Operation class, codes 0 to 12 as in R3 to R11 |
| cond | input | 3 | Condition code for ops 1, 3 and 5 |
| rst_vec | input | 3 | Restart vector n for op 6 |
| pair_sel | input | 2 | Register pair for ops 7 and 9 |
| flags | input | DW | Flag byte |
| acc | input | DW | Accumulator |
| bc | input | 2*DW | BC pair |
| de | input | 2*DW | DE pair |
| hl | input | 2*DW | HL pair |
| mem_rdata | input | DW | Read data, valid in the same cycle |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_addr | output | 2*DW | Access address |
| mem_wdata | output | DW | Write data |
| wb_en | output | 1 | Register write-back strobe |
| wb_dst | output | 3 | Write-back destination code |
| wb_data | output | 2*DW | Write-back value (bytes in the low part) |
| pc | output | 2*DW | Program counter |
| sp | output | 2*DW | Stack pointer |
| mcycle | output | 3 | Current machine cycle, 0 = M1 to 4 = M5 |
| ready | output | 1 | In M1, able to take `start` |
| done | output | 1 | Final cycle of the instruction |

## Verification
Two states are hard to reach from the ports: a conditional return that finds a return address it has itself placed on the stack, and a flag pattern that makes exactly the desired test pass. The stimulus sweeps every condition code over all sixteen combinations of the four tested flags, first for jumps, then for calls. The calls leave a deep stack of known return addresses. The conditional-return sweep then unwinds that stack, and since the number of passing tests in both sweeps is the same, it ends back at `sp` 0. Pushes feed the status pop and the exchange, so their stack contents are also known to the bench in advance.

// File: rtl/stk_pkg.sv
`timescale 1ns/1ps
package stk_pkg;

    typedef enum logic [3:0] {
        OP_JMP     = 4'd0,
        OP_JCOND   = 4'd1,
        OP_CALL    = 4'd2,
        OP_CCOND   = 4'd3,
        OP_RET     = 4'd4,
        OP_RCOND   = 4'd5,
        OP_RST     = 4'd6,
        OP_PUSH    = 4'd7,
        OP_PUSHST  = 4'd8,
        OP_POP     = 4'd9,
        OP_POPST   = 4'd10,
        OP_XCHG    = 4'd11,
        OP_HLJUMP  = 4'd12,
        OP_NONE13  = 4'd13,
        OP_NONE14  = 4'd14,
        OP_NONE15  = 4'd15
    } stk_op_e;

    typedef enum logic [2:0] {
        MC1 = 3'd0,
        MC2 = 3'd1,
        MC3 = 3'd2,
        MC4 = 3'd3,
        MC5 = 3'd4
    } mcyc_e;

    typedef enum logic [2:0] {
        DST_BC  = 3'd0,
        DST_DE  = 3'd1,
        DST_HL  = 3'd2,
        DST_FLG = 3'd3,
        DST_ACC = 3'd4
    } wb_dst_e;

    localparam int FLG_CY = 0;
    localparam int FLG_P  = 2;
    localparam int FLG_Z  = 6;
    localparam int FLG_S  = 7;

endpackage

// File: rtl/stk_cond_eval.sv
`timescale 1ns/1ps
module stk_cond_eval (
    input  logic [2:0] code,
    input  logic       f_sign,
    input  logic       f_zero,
    input  logic       f_par,
    input  logic       f_carry,
    output logic       pass
);
    // code[2:1] picks the flag, code[0] the polarity wanted
    logic [3:0] tested;
    assign tested = {f_sign, f_par, f_carry, f_zero};
    assign pass   = (tested[code[2:1]] == code[0]);
endmodule

// File: rtl/stk_len.sv
`timescale 1ns/1ps
module stk_len
    import stk_pkg::*;
(
    input  stk_op_e op,
    output mcyc_e   last
);
    always_comb begin
        case (op)
            OP_JMP, OP_JCOND, OP_RET, OP_RCOND, OP_RST,
            OP_PUSH, OP_PUSHST, OP_POP, OP_POPST:      last = MC3;
            OP_CALL, OP_CCOND, OP_XCHG:                last = MC5;
            default:                                   last = MC1;
        endcase
    end
endmodule

// File: rtl/stk_branch_seq.sv
`timescale 1ns/1ps
module stk_branch_seq
    import stk_pkg::*;
#(
    parameter  int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    op,
    input  logic [2:0]    cond,
    input  logic [2:0]    rst_vec,
    input  logic [1:0]    pair_sel,
    input  logic [DW-1:0] flags,
    input  logic [DW-1:0] acc,
    input  logic [AW-1:0] bc,
    input  logic [AW-1:0] de,
    input  logic [AW-1:0] hl,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          wb_en,
    output logic [2:0]    wb_dst,
    output logic [AW-1:0] wb_data,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] sp,
    output logic [2:0]    mcycle,
    output logic          ready,
    output logic          done
);

    localparam logic [DW-1:0] STAT_KEEP = DW'(8'hD5);
    localparam logic [DW-1:0] STAT_ONE  = DW'(8'h02);
    localparam int            VEC_PAD   = AW - 6;

    typedef struct packed {
        mcyc_e         cyc;
        stk_op_e       op;
        logic [1:0]    sel;
        logic [2:0]    vec;
        logic [AW-1:0] pc;
        logic [AW-1:0] sp;
        logic [DW-1:0] w;
        logic [DW-1:0] z;
    } seq_t;

    seq_t q, d;

    logic          cond_ok;
    mcyc_e         last_cyc;
    stk_op_e       op_in;
    logic [AW-1:0] pair_val;
    logic [DW-1:0] stat_byte;
    logic [AW-1:0] vec_addr;

    assign op_in     = stk_op_e'(op);
    assign stat_byte = (flags & STAT_KEEP) | STAT_ONE;
    assign vec_addr  = {{VEC_PAD{1'b0}}, q.vec, 3'b000};

    always_comb begin
        case (q.sel)
            2'd0:    pair_val = bc;
            2'd1:    pair_val = de;
            default: pair_val = hl;
        endcase
    end

    stk_cond_eval u_cond (
        .code    (cond),
        .f_sign  (flags[FLG_S]),
        .f_zero  (flags[FLG_Z]),
        .f_par   (flags[FLG_P]),
        .f_carry (flags[FLG_CY]),
        .pass    (cond_ok)
    );

    stk_len u_len (
        .op   (q.op),
        .last (last_cyc)
    );

    always_comb begin
        d         = q;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        wb_en     = 1'b0;
        wb_dst    = DST_BC;
        wb_data   = '0;
        done      = 1'b0;

        case (q.cyc)
            MC1: begin
                if (start) begin
                    d.op  = op_in;
                    d.sel = pair_sel;
                    d.vec = rst_vec;
                    case (op_in)
                        OP_JMP, OP_RET, OP_POP, OP_POPST, OP_XCHG: ;
                        OP_JCOND: begin
                            if (cond_ok) d.op = OP_JMP;
                            else begin
                                d.pc = q.pc + AW'(2);
                                done = 1'b1;
                            end
                        end
                        OP_CALL: d.sp = q.sp - AW'(1);
                        OP_CCOND: begin
                            if (cond_ok) begin
                                d.op = OP_CALL;
                                d.sp = q.sp - AW'(1);
                            end else begin
                                d.pc = q.pc + AW'(2);
                                done = 1'b1;
                            end
                        end
                        OP_RCOND: begin
                            if (cond_ok) d.op = OP_RET;
                            else         done = 1'b1;
                        end
                        OP_RST, OP_PUSH, OP_PUSHST: d.sp = q.sp - AW'(1);
                        OP_HLJUMP: begin
                            d.pc = hl;
                            done = 1'b1;
                        end
                        default: done = 1'b1;
                    endcase
                end
            end

            MC2: begin
                case (q.op)
                    OP_JMP, OP_CALL: begin
                        mem_rd   = 1'b1;
                        mem_addr = q.pc;
                        d.z      = mem_rdata;
                        d.pc     = q.pc + AW'(1);
                    end
                    OP_RET, OP_POP, OP_XCHG: begin
                        mem_rd   = 1'b1;
                        mem_addr = q.sp;
                        d.z      = mem_rdata;
                        d.sp     = q.sp + AW'(1);
                    end
                    OP_POPST: begin
                        mem_rd   = 1'b1;
                        mem_addr = q.sp;
                        d.sp     = q.sp + AW'(1);
                        wb_en    = 1'b1;
                        wb_dst   = DST_FLG;
                        wb_data  = AW'(mem_rdata);
                    end
                    OP_RST: begin
                        mem_wr    = 1'b1;
                        mem_addr  = q.sp;
                        mem_wdata = q.pc[AW-1:DW];
                        d.sp      = q.sp - AW'(1);
                    end
                    OP_PUSH: begin
                        mem_wr    = 1'b1;
                        mem_addr  = q.sp;
                        mem_wdata = pair_val[AW-1:DW];
                        d.sp      = q.sp - AW'(1);
                    end
                    OP_PUSHST: begin
                        mem_wr    = 1'b1;
                        mem_addr  = q.sp;
                        mem_wdata = acc;
                        d.sp      = q.sp - AW'(1);
                    end
                    default: ;
                endcase
            end

            MC3: begin
                case (q.op)
                    OP_JMP: begin
                        mem_rd   = 1'b1;
                        mem_addr = q.pc;
                        d.w      = mem_rdata;
                        d.pc     = {mem_rdata, q.z};
                        done     = 1'b1;
                    end
                    OP_CALL: begin
                        mem_rd   = 1'b1;
                        mem_addr = q.pc;
                        d.w      = mem_rdata;
                        d.pc     = q.pc + AW'(1);
                    end
                    OP_RET: begin
                        mem_rd   = 1'b1;
                        mem_addr = q.sp;
                        d.w      = mem_rdata;
                        d.sp     = q.sp + AW'(1);
                        d.pc     = {mem_rdata, q.z};
                        done     = 1'b1;
                    end
                    OP_POP: begin
                        mem_rd   = 1'b1;
                        mem_addr = q.sp;
                        d.w      = mem_rdata;
                        d.sp     = q.sp + AW'(1);
                        wb_en    = 1'b1;
                        wb_dst   = (q.sel == 2'd0) ? DST_BC :
                                   (q.sel == 2'd1) ? DST_DE : DST_HL;
                        wb_data  = {mem_rdata, q.z};
                        done     = 1'b1;
                    end
                    OP_POPST: begin
                        mem_rd   = 1'b1;
                        mem_addr = q.sp;
                        d.sp     = q.sp + AW'(1);
                        wb_en    = 1'b1;
                        wb_dst   = DST_ACC;
                        wb_data  = AW'(mem_rdata);
                        done     = 1'b1;
                    end
                    OP_XCHG: begin
                        mem_rd   = 1'b1;
                        mem_addr = q.sp;
                        d.w      = mem_rdata;
                    end
                    OP_RST: begin
                        mem_wr    = 1'b1;
                        mem_addr  = q.sp;
                        mem_wdata = q.pc[DW-1:0];
                        d.w       = vec_addr[AW-1:DW];
                        d.z       = vec_addr[DW-1:0];
                        d.pc      = vec_addr;
                        done      = 1'b1;
                    end
                    OP_PUSH: begin
                        mem_wr    = 1'b1;
                        mem_addr  = q.sp;
                        mem_wdata = pair_val[DW-1:0];
                        done      = 1'b1;
                    end
                    OP_PUSHST: begin
                        mem_wr    = 1'b1;
                        mem_addr  = q.sp;
                        mem_wdata = stat_byte;
                        done      = 1'b1;
                    end
                    default: ;
                endcase
            end

            MC4: begin
                case (q.op)
                    OP_CALL: begin
                        mem_wr    = 1'b1;
                        mem_addr  = q.sp;
                        mem_wdata = q.pc[AW-1:DW];
                        d.sp      = q.sp - AW'(1);
                    end
                    OP_XCHG: begin
                        mem_wr    = 1'b1;
                        mem_addr  = q.sp;
                        mem_wdata = hl[AW-1:DW];
                        d.sp      = q.sp - AW'(1);
                    end
                    default: ;
                endcase
            end

            MC5: begin
                case (q.op)
                    OP_CALL: begin
                        mem_wr    = 1'b1;
                        mem_addr  = q.sp;
                        mem_wdata = q.pc[DW-1:0];
                        d.pc      = {q.w, q.z};
                        done      = 1'b1;
                    end
                    OP_XCHG: begin
                        mem_wr    = 1'b1;
                        mem_addr  = q.sp;
                        mem_wdata = hl[DW-1:0];
                        wb_en     = 1'b1;
                        wb_dst    = DST_HL;
                        wb_data   = {q.w, q.z};
                        done      = 1'b1;
                    end
                    default: ;
                endcase
            end

            default: ;
        endcase

        if (done)
            d.cyc = MC1;
        else if (q.cyc != MC1 || start)
            d.cyc = mcyc_e'(q.cyc + 3'd1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cyc <= MC1;
            q.op  <= OP_NONE15;
            q.sel <= '0;
            q.vec <= '0;
            q.pc  <= '0;
            q.sp  <= '0;
            q.w   <= '0;
            q.z   <= '0;
        end else begin
            q <= d;
        end
    end

    assign pc     = q.pc;
    assign sp     = q.sp;
    assign mcycle = q.cyc;
    assign ready  = (q.cyc == MC1);

    // R13: one access at most, never in M1
    assert_single_access_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    assert_no_m1_access_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !(mem_rd || mem_wr));

    // R4/R5/R6: a multi-cycle instruction ends exactly at its class length
    assert_cycle_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ready) |-> (q.cyc == last_cyc));

    // R3: failed conditional branch skips the two address bytes
    assert_cond_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start && (op_in == OP_JCOND || op_in == OP_CCOND) && !cond_ok)
        |=> (pc == $past(pc) + AW'(2)));

    // R8: second pushed byte lands one below the first
    assert_push_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cyc == MC3 && (q.op == OP_PUSH || q.op == OP_PUSHST))
        |-> (mem_wr && mem_addr == $past(mem_addr) - AW'(1)));

    // R10: exchange leaves the stack pointer where it began
    assert_xchg_sp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cyc == MC5 && q.op == OP_XCHG) |=> (sp == $past(sp, 5)));

endmodule

// File: tb/stk_branch_seq_bench.sv
`timescale 1ns/1ps
module stk_branch_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [2:0]  cond = 3'd0;
    logic [2:0]  rst_vec = 3'd0;
    logic [1:0]  pair_sel = 2'd0;
    logic [7:0]  flg = 8'h02;
    logic [7:0]  acc = 8'h00;
    logic [15:0] bc = 16'h0, de = 16'h0, hl = 16'h0;
    logic [7:0]  mem_rdata;
    logic        mem_rd, mem_wr, wb_en, ready, done;
    logic [15:0] mem_addr, wb_data, pc, sp;
    logic [7:0]  mem_wdata;
    logic [2:0]  wb_dst, mcycle;

    logic [7:0]  mem [0:1023];
    logic [7:0]  xm  [0:1023];
    int          vecs = 0, bad = 0, acc_cnt = 0;
    bit          finished = 0;
    logic [15:0] e_pc = 16'h0, e_sp = 16'h0;

    always #2 clk = ~clk;

    stk_branch_seq u_stk_branch_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cond(cond),
        .rst_vec(rst_vec), .pair_sel(pair_sel), .flags(flg), .acc(acc),
        .bc(bc), .de(de), .hl(hl), .mem_rdata(mem_rdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .wb_en(wb_en), .wb_dst(wb_dst),
        .wb_data(wb_data), .pc(pc), .sp(sp), .mcycle(mcycle),
        .ready(ready), .done(done));

    assign mem_rdata = mem[mem_addr[9:0]];

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
        if (mem_rd || mem_wr) acc_cnt <= acc_cnt + 1;
        if (wb_en) begin
            case (wb_dst)
                3'd0: bc  <= wb_data;
                3'd1: de  <= wb_data;
                3'd2: hl  <= wb_data;
                3'd3: flg <= wb_data[7:0];
                3'd4: acc <= wb_data[7:0];
                default: ;
            endcase
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [15:0] a, input logic [7:0] v);
        mem[a[9:0]] = v;
        xm[a[9:0]]  = v;
    endtask

    task automatic run(input logic [3:0] o, input logic [2:0] c,
                       input logic [2:0] v, input logic [1:0] s, output int cyc);
        bit fin;
        @(negedge clk);
        op = o; cond = c; rst_vec = v; pair_sel = s;
        acc_cnt = 0;
        start = 1'b1;
        #1;
        cyc = 0;
        fin = 0;
        while (!fin && cyc < 8) begin
            cyc++;
            fin = done;
            if (!fin) begin
                @(negedge clk);
                start = 1'b0;
                #1;
            end
        end
        @(negedge clk);
        start = 1'b0;
    endtask

    function automatic logic [7:0] mkflags(input logic [3:0] k);
        return {k[3], k[2], 1'b0, 1'b0, 1'b0, k[1], 1'b1, k[0]};
    endfunction

    // k[3]=sign k[2]=zero k[1]=parity k[0]=carry
    function automatic bit ref_cond(input logic [2:0] c, input logic [3:0] k);
        case (c)
            3'd0: return !k[2];
            3'd1: return  k[2];
            3'd2: return !k[0];
            3'd3: return  k[0];
            3'd4: return !k[1];
            3'd5: return  k[1];
            3'd6: return !k[3];
            default: return k[3];
        endcase
    endfunction

    task automatic report;
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        bad++;
        $display("FAIL watchdog: actual hung expected completion");
        report();
    end

    initial begin
        int cyc;
        logic [15:0] tgt, ret;
        bit ok;
        for (int i = 0; i < 1024; i++) begin mem[i] = 8'h00; xm[i] = 8'h00; end
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk("R1", "pc", pc, 0);
        chk("R1", "sp", sp, 0);
        chk("R1", "ready", ready, 1);
        chk("R1", "mcycle", mcycle, 0);
        chk("R1", "access", mem_rd | mem_wr, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4 plain jump
        put(16'h0000, 8'h40); put(16'h0001, 8'h00);
        run(4'd0, 3'd0, 3'd0, 2'd0, cyc);
        e_pc = 16'h0040;
        chk("R4", "jmp cycles", cyc, 3);
        chk("R4", "jmp pc", pc, e_pc);

        // R2/R3/R4 conditional jump sweep
        for (int c = 0; c < 8; c++) begin
            for (int k = 0; k < 16; k++) begin
                tgt = 16'h0040 + 16'(((c * 16 + k) * 37) % 128) * 16'd4;
                put(e_pc, tgt[7:0]); put(e_pc + 16'd1, tgt[15:8]);
                flg = mkflags(4'(k));
                ok = ref_cond(3'(c), 4'(k));
                run(4'd1, 3'(c), 3'd0, 2'd0, cyc);
                e_pc = ok ? tgt : e_pc + 16'd2;
                chk(ok ? "R4" : "R3", "jcond cycles", cyc, ok ? 3 : 1);
                chk("R2", "jcond pc", pc, e_pc);
            end
        end

        // R5 plain call
        tgt = 16'h0100;
        put(e_pc, tgt[7:0]); put(e_pc + 16'd1, tgt[15:8]);
        ret = e_pc + 16'd2;
        run(4'd2, 3'd0, 3'd0, 2'd0, cyc);
        e_sp = e_sp - 16'd2;
        xm[e_sp[9:0] + 10'd1] = ret[15:8]; xm[e_sp[9:0]] = ret[7:0];
        e_pc = tgt;
        chk("R5", "call cycles", cyc, 5);
        chk("R5", "call pc", pc, e_pc);
        chk("R5", "call sp", sp, e_sp);
        chk("R5", "call hi", mem[e_sp[9:0] + 10'd1], ret[15:8]);
        chk("R5", "call lo", mem[e_sp[9:0]], ret[7:0]);

        // R2/R3/R5 conditional call sweep
        for (int c = 0; c < 8; c++) begin
            for (int k = 0; k < 16; k++) begin
                tgt = 16'h0040 + 16'(((c * 16 + k) * 53) % 128) * 16'd4;
                put(e_pc, tgt[7:0]); put(e_pc + 16'd1, tgt[15:8]);
                flg = mkflags(4'(k));
                ok = ref_cond(3'(c), 4'(k));
                ret = e_pc + 16'd2;
                run(4'd3, 3'(c), 3'd0, 2'd0, cyc);
                if (ok) begin
                    e_sp = e_sp - 16'd2;
                    xm[e_sp[9:0] + 10'd1] = ret[15:8]; xm[e_sp[9:0]] = ret[7:0];
                    e_pc = tgt;
                    chk("R5", "ccond stack", {mem[e_sp[9:0] + 10'd1], mem[e_sp[9:0]]}, ret);
                end else begin
                    e_pc = e_pc + 16'd2;
                    chk("R3", "ccond access", acc_cnt, 0);
                end
                chk(ok ? "R5" : "R3", "ccond cycles", cyc, ok ? 5 : 1);
                chk("R2", "ccond pc", pc, e_pc);
                chk("R3", "ccond sp", sp, e_sp);
            end
        end

        // R6 plain return
        run(4'd4, 3'd0, 3'd0, 2'd0, cyc);
        e_pc = {xm[e_sp[9:0] + 10'd1], xm[e_sp[9:0]]};
        e_sp = e_sp + 16'd2;
        chk("R6", "ret cycles", cyc, 3);
        chk("R6", "ret pc", pc, e_pc);
        chk("R6", "ret sp", sp, e_sp);

        // R2/R6 conditional return sweep
        for (int c = 0; c < 8; c++) begin
            for (int k = 0; k < 16; k++) begin
                flg = mkflags(4'(k));
                ok = ref_cond(3'(c), 4'(k));
                run(4'd5, 3'(c), 3'd0, 2'd0, cyc);
                if (ok) begin
                    e_pc = {xm[e_sp[9:0] + 10'd1], xm[e_sp[9:0]]};
                    e_sp = e_sp + 16'd2;
                end
                chk("R6", "rcond cycles", cyc, ok ? 3 : 1);
                chk("R2", "rcond pc", pc, e_pc);
                chk("R6", "rcond sp", sp, e_sp);
            end
        end
        chk("R6", "stack unwound", sp, 16'h0000);

        // R7 restart for every vector
        for (int v = 0; v < 8; v++) begin
            ret = e_pc;
            run(4'd6, 3'd0, 3'(v), 2'd0, cyc);
            e_sp = e_sp - 16'd2;
            e_pc = 16'(v * 8);
            chk("R7", "rst cycles", cyc, 3);
            chk("R7", "rst pc", pc, e_pc);
            chk("R7", "rst sp", sp, e_sp);
            chk("R7", "rst stack", {mem[e_sp[9:0] + 10'd1], mem[e_sp[9:0]]}, ret);
        end

        // R8 pushes
        bc = 16'hA1B2; de = 16'hC3D4; hl = 16'hE5F6; acc = 8'h5C; flg = 8'hFF;
        for (int s = 0; s < 3; s++) begin
            ret = (s == 0) ? bc : (s == 1) ? de : hl;
            run(4'd7, 3'd0, 3'd0, 2'(s), cyc);
            e_sp = e_sp - 16'd2;
            chk("R8", "push cycles", cyc, 3);
            chk("R8", "push sp", sp, e_sp);
            chk("R8", "push hi", mem[e_sp[9:0] + 10'd1], ret[15:8]);
            chk("R8", "push lo", mem[e_sp[9:0]], ret[7:0]);
            chk("R13", "push accesses", acc_cnt, 2);
        end
        run(4'd8, 3'd0, 3'd0, 2'd0, cyc);
        e_sp = e_sp - 16'd2;
        chk("R8", "pushst cycles", cyc, 3);
        chk("R8", "pushst acc", mem[e_sp[9:0] + 10'd1], 8'h5C);
        chk("R8", "pushst flags", mem[e_sp[9:0]], 8'hD7);

        // R9 pops
        acc = 8'h00; flg = 8'h00;
        run(4'd10, 3'd0, 3'd0, 2'd0, cyc);
        e_sp = e_sp + 16'd2;
        chk("R9", "popst cycles", cyc, 3);
        chk("R9", "popst flags", flg, 8'hD7);
        chk("R9", "popst acc", acc, 8'h5C);
        chk("R9", "popst sp", sp, e_sp);
        run(4'd9, 3'd0, 3'd0, 2'd0, cyc);
        e_sp = e_sp + 16'd2;
        chk("R9", "pop cycles", cyc, 3);
        chk("R9", "pop bc", bc, 16'hE5F6);
        chk("R9", "pop sp", sp, e_sp);

        // R10 exchange with top of stack (holds DE image C3D4)
        hl = 16'h1357;
        run(4'd11, 3'd0, 3'd0, 2'd0, cyc);
        chk("R10", "xchg cycles", cyc, 5);
        chk("R10", "xchg hl", hl, 16'hC3D4);
        chk("R10", "xchg stack", {mem[e_sp[9:0] + 10'd1], mem[e_sp[9:0]]}, 16'h1357);
        chk("R10", "xchg sp", sp, e_sp);

        // R11 HL jump
        run(4'd12, 3'd0, 3'd0, 2'd0, cyc);
        e_pc = 16'hC3D4;
        chk("R11", "hljump cycles", cyc, 1);
        chk("R11", "hljump pc", pc, e_pc);
        chk("R11", "hljump access", acc_cnt, 0);

        // R12 unassigned codes
        for (int o = 13; o < 16; o++) begin
            run(4'(o), 3'd0, 3'd0, 2'd0, cyc);
            chk("R12", "none cycles", cyc, 1);
            chk("R12", "none pc", pc, e_pc);
            chk("R12", "none sp", sp, e_sp);
            chk("R12", "none access", acc_cnt, 0);
        end
        report();
    end

endmodule